// File: doc/BRIEF.md
# SD/MMC Controller Status and Interrupt Mask Unit

This unit holds the status word of an SD/MMC host controller and drives two interrupt lines from it. The command and data paths signal completions and errors by single-cycle event pulses. Each pulse sets a sticky flag, and the flag stays set until software writes a one to the matching bit of the clear register. The FIFO and activity logic supply level signals. These levels appear in the status word as they are, with no latching.

Software reaches four word-wide registers through a simple read port and a simple write port. The registers are status (read only), clear (write only), interrupt mask 0 and interrupt mask 1. Each interrupt line is a registered OR over the status bits that its own mask enables. A typical driver sets a mask, starts a transfer and waits for its interrupt line. It then reads the status word to find the cause and writes the sticky bits back to the clear register to acknowledge them.

Top module: `mmc_stat_irq`

## Requirements
- R1: After reset the status word reads zero when all level inputs are low. Both masks read zero and both interrupt lines are low.
- R2: A pulse on event input e sets status bit e for e in 0..8. A pulse on event input 9 sets status bit 10. The event inputs are, in order: command CRC fail, data CRC fail, command timeout, data timeout, transmit underrun, receive overrun, response end, command sent, data end, data block end.
- R3: A sticky bit stays set until a write to the clear register (address 1) has a one in that bit position. Zeros in a clear write leave sticky bits unchanged.
- R4: If an event pulse and a clear of the same bit occur in the same cycle, the bit ends up set.
- R5: Status bits 11 to 21 show level inputs 0 to 10 directly. These are, in order: command active, transmit active, receive active, transmit half empty, receive half full, transmit full, receive full, transmit empty, receive empty, transmit data available, receive data available. Clear writes do not change them.
- R6: Status bit 9 and bits 22 to 31 always read zero.
- R7: Interrupt line 0 is the OR of status AND mask 0, and line 1 is the OR of status AND mask 1. Each line is registered and changes one cycle after the status or mask change that causes it. The two masks act independently.
- R8: While a mask is zero, its interrupt line stays low whatever the status.
- R9: The register addresses are 0 for status, 1 for clear, 2 for mask 0 and 3 for mask 1. Read data is registered and appears one cycle after the address. The clear address reads zero, and writes to the status address are ignored.
- R10: A clear write of all ones resets every sticky bit in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 10 | Single-cycle event pulses from the command and data paths |
| lvl_in | input | 11 | Live FIFO and activity levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Registered read data |
| irq0 | output | 1 | Interrupt line enabled by mask 0 |
| irq1 | output | 1 | Interrupt line enabled by mask 1 |

## Verification
The assertions take the level inputs to be synchronous to the clock, so a level sampled on one edge is the one that reaches the status read on that edge. They also take each event input to pulse for a single cycle, with no external duty on its width. The stimulus drives every input at the falling edge and holds it through the following rising edge. It sweeps each event and level position one at a time, and it overlaps a pulse with a clear of the same bit only in the dedicated set-versus-clear case.

// File: rtl/mmc_stat_pkg.sv
package mmc_stat_pkg;
  localparam int WORD_W  = 32;
  localparam int NUM_EVT = 10;
  localparam int NUM_LVL = 11;
  localparam int LVL_LSB = 11;
  localparam int ADDR_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_STAT = 2'd0,
    A_CLR  = 2'd1,
    A_MSK0 = 2'd2,
    A_MSK1 = 2'd3
  } reg_addr_e;

  // status bit position of event input e; bit 9 is a hole
  function automatic int evt_pos(input int e);
    return (e < 9) ? e : 10;
  endfunction
endpackage

// File: rtl/mmc_stat_sticky.sv
module mmc_stat_sticky #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= (q & ~clr_i[i]) | set_i[i];
    end
    assign flag_o[i] = q;

    p_set_r2: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> flag_o[i]);
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (flag_o[i] && !clr_i[i]) |=> flag_o[i]);
    p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
      (set_i[i] && clr_i[i]) |=> flag_o[i]);
  end
endmodule

// File: rtl/mmc_stat_mask_irq.sv
module mmc_stat_mask_irq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] status,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);
  logic [W-1:0] mask_q;
  logic         irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (we) mask_q <= wdata;
      irq_q <= |(status & mask_q);
    end
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  p_mask_zero_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq_o);
  p_irq_raise_r7: assert property (@(posedge clk) disable iff (rst)
    ((status & mask_q) != '0) |=> irq_o);
endmodule

// File: rtl/mmc_stat_irq.sv
module mmc_stat_irq
  import mmc_stat_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic [NUM_LVL-1:0] lvl_in,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [WORD_W-1:0]  rd_data,
  output logic               irq0,
  output logic               irq1
);
  localparam int NUM_IRQ = 2;

  logic [NUM_EVT-1:0] clr_vec, flags;
  logic [WORD_W-1:0]  status;
  logic [WORD_W-1:0]  mask [NUM_IRQ];
  logic [NUM_IRQ-1:0] irq;
  logic               clr_stb;

  assign clr_stb = wr_en && (wr_addr == A_CLR);

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_clr
    assign clr_vec[e] = clr_stb & wr_data[evt_pos(e)];
  end

  mmc_stat_sticky #(.N(NUM_EVT)) u_sticky (
    .clk(clk), .rst(rst), .set_i(evt_pulse), .clr_i(clr_vec), .flag_o(flags)
  );

  always_comb begin
    status = '0;
    for (int e = 0; e < NUM_EVT; e++) status[evt_pos(e)] = flags[e];
    status[LVL_LSB +: NUM_LVL] = lvl_in;
  end

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
    mmc_stat_mask_irq #(.W(WORD_W)) u_mask (
      .clk(clk), .rst(rst),
      .we(wr_en && (wr_addr == ADDR_W'(A_MSK0) + ADDR_W'(k))),
      .wdata(wr_data), .status(status),
      .mask_o(mask[k]), .irq_o(irq[k])
    );
  end

  assign irq0 = irq[0];
  assign irq1 = irq[1];

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      unique case (rd_addr)
        A_STAT:  rd_data <= status;
        A_MSK0:  rd_data <= mask[0];
        A_MSK1:  rd_data <= mask[1];
        default: rd_data <= '0;
      endcase
    end
  end

  p_unused_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == A_STAT) |=> (rd_data[9] == 1'b0 && rd_data[31:22] == '0));
  p_live_follow_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == A_STAT) |=> (rd_data[LVL_LSB +: NUM_LVL] == $past(lvl_in)));
  p_clr_reads_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == A_CLR) |=> (rd_data == '0));
endmodule

// File: tb/sim_mmc_stat_irq.sv
module sim_mmc_stat_irq;
  logic        clk = 0, rst = 1;
  logic [9:0]  evt_pulse = '0;
  logic [10:0] lvl_in = '0;
  logic        wr_en = 0;
  logic [1:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic        irq0, irq1;
  int          n_chk = 0, n_err = 0;
  logic [31:0] exp_st;

  always #2 clk = ~clk;

  mmc_stat_irq u0 (.*);

  function automatic int pos(input int e);
    return (e < 9) ? e : 10;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic pulse(input logic [9:0] v);
    evt_pulse = v;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    #200000;
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    @(negedge clk); @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(2'd0, d); check("R1 status", d, 32'h0);
    rd(2'd2, d); check("R1 mask0", d, 32'h0);
    rd(2'd3, d); check("R1 mask1", d, 32'h0);
    check("R1 irqs", {30'h0, irq1, irq0}, 32'h0);

    // R2/R3/R7 sweep over each event position
    for (int e = 0; e < 10; e++) begin
      exp_st = 32'h1 << pos(e);
      pulse(10'h1 << e);
      rd(2'd0, d); check("R2 event sets bit", d, exp_st);
      wr(2'd1, ~exp_st);  // zeros at this bit: no effect
      rd(2'd0, d); check("R3 zero clear keeps", d, exp_st);
      wr(2'd2, exp_st); settle();
      check("R7 irq0 follows mask0", {30'h0, irq1, irq0}, 32'h1);
      wr(2'd3, exp_st); settle();
      check("R7 irq1 follows mask1", {30'h0, irq1, irq0}, 32'h3);
      wr(2'd2, ~exp_st); settle();
      check("R7 independent masks", {30'h0, irq1, irq0}, 32'h2);
      wr(2'd1, exp_st);
      rd(2'd0, d); check("R3 clear one bit", d, 32'h0);
      settle();
      check("R7 irq drops after clear", {30'h0, irq1, irq0}, 32'h0);
      wr(2'd2, 32'h0); wr(2'd3, 32'h0);
    end

    // R9 mask readback and clear address reads zero, status write ignored
    wr(2'd2, 32'hA5A5_1234); wr(2'd3, 32'h5A5A_8765);
    rd(2'd2, d); check("R9 mask0 readback", d, 32'hA5A5_1234);
    rd(2'd3, d); check("R9 mask1 readback", d, 32'h5A5A_8765);
    rd(2'd1, d); check("R9 clear reads zero", d, 32'h0);
    wr(2'd2, 32'h0); wr(2'd3, 32'h0);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); check("R9 status write ignored", d, 32'h0);

    // R5 live bits sweep, clear writes have no effect
    for (int l = 0; l < 11; l++) begin
      lvl_in = 11'h1 << l;
      rd(2'd0, d); check("R5 live bit", d, 32'h1 << (11 + l));
      wr(2'd1, 32'hFFFF_FFFF);
      rd(2'd0, d); check("R5 clear ignores live", d, 32'h1 << (11 + l));
      wr(2'd3, 32'h1 << (11 + l)); settle();
      check("R7 live drives irq1", {30'h0, irq1, irq0}, 32'h2);
      wr(2'd3, 32'h0);
    end
    lvl_in = '0;
    settle();

    // R8 everything set, both masks zero
    lvl_in = '1;
    pulse(10'h3FF);
    rd(2'd0, d); check("R6 full status", d, 32'h003F_FDFF);
    settle(); settle();
    check("R8 no irq with zero masks", {30'h0, irq1, irq0}, 32'h0);
    wr(2'd2, 32'h0000_0200); wr(2'd3, 32'hFFC0_0000); settle();
    check("R6 hole bits never interrupt", {30'h0, irq1, irq0}, 32'h0);
    wr(2'd2, 32'h0); wr(2'd3, 32'h0);
    lvl_in = '0;

    // R10 clear all
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd0, d); check("R10 clear all", d, 32'h0);

    // R4 set and clear of the same bit together
    pulse(10'h010);
    evt_pulse = 10'h010; wr(2'd1, 32'h0000_0010); evt_pulse = '0;
    rd(2'd0, d); check("R4 set wins", d, 32'h0000_0010);
    pulse(10'h200);
    evt_pulse = 10'h200; wr(2'd1, 32'h0000_0400); evt_pulse = '0;
    rd(2'd0, d); check("R4 set wins bit10", d, 32'h0000_0410);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd0, d); check("R10 final clear", d, 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule